// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers interrupt requests from a large set of peripheral lines and from a small group of sources that software raises and drops through register writes. Every source carries a programmable 4-bit priority. The block picks the most urgent pending source and presents it to a processor as one interrupt line plus a 9-bit vector number. A source is forwarded only when its priority is strictly above a current-priority level that the block maintains.

When the processor takes an interrupt, it reads the acknowledge register. That read returns the vector, saves the running priority in a hardware stack, and makes the acknowledged source's priority the new running level. Writing the end-of-interrupt register restores the saved level. Software may also overwrite the running level directly. This lets a task raise its own level for a while, so that tasks sharing a resource cannot preempt one another (priority ceiling).

Peripheral requests are level inputs. A request reaches the interrupt output after three clock edges. Software-raised sources pass through the same arbitration path as peripheral requests.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0, the running priority reads 0, every source priority reads 0, and the software pending bits read 0.
- R2: A peripheral request that becomes the winner is visible on irq_o after the third rising edge following its assertion, and not before.
- R3: The reported vector equals the source index. Peripheral line k is index k. Software source j is index N_PERIPH+j.
- R4: Among pending sources, the highest priority wins. If several sources tie at that priority, the lowest index wins.
- R5: A source is forwarded only when its priority is strictly greater than the running priority. Equal or lower priorities stay pending, and priority 0 is never forwarded.
- R6: A read of address 1 while irq_o is 1 returns bit 15 = 1 and the vector in bits 8:0. It pushes the running priority onto the stack, loads the acknowledged source's priority as the new running priority, and drops irq_o on the next edge.
- R7: A write to address 2 pops the stack into the running priority. A pop on an empty stack sets the running priority to 0. The stack holds 16 entries.
- R8: A write to address 0 sets the running priority to bits 3:0 of the data without touching the stack, and a read of address 0 returns it.
- R9: A write to address 3 sets each software pending bit whose data bit is 1. A write to address 4 clears each bit whose data bit is 1. A read of address 3 returns the pending bits.
- R10: The priority of source i lives at address 256+i in bits 3:0 and can be read back.
- R11: A read of address 1 while irq_o is 0 returns bit 15 = 0 and leaves the running priority and stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_req | input | N_PERIPH | Level-sensitive peripheral request lines |
| addr | input | 10 | Register word address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | max(N_SW,4) | Register write data |
| rd_en | input | 1 | Register read strobe (acknowledge when addr is 1) |
| rd_data | output | 16 | Register read data |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_vec_o | output | 9 | Vector of the forwarded source |

## Verification
The embedded properties check the following on every cycle:
- an asserted irq_o always carries a priority above the previous running level;
- an acknowledge always loads the source priority and clears irq_o;
- the stack never exceeds its depth;
- popping an empty stack yields 0;
- a ceiling write leaves the stack depth alone;
- the software set and clear strobes take effect.

Other behaviours can only be shown by the bench's scenarios:
- the exact three-edge latency;
- the lowest-index tie-break;
- the nesting order of pushes and pops across several levels;
- the equivalence of software and peripheral sources.

The random phase also compares every acknowledge against a reference model built from priorities, pending lines and a model stack.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W        = 4;
  localparam int VEC_W         = 9;
  localparam int ADDR_W        = 10;
  localparam int RD_W          = 16;
  localparam int ACK_VALID_BIT = 15;
  localparam int PRIO_BASE     = 256;

  localparam logic [ADDR_W-1:0] A_CUR   = 10'd0;
  localparam logic [ADDR_W-1:0] A_ACK   = 10'd1;
  localparam logic [ADDR_W-1:0] A_EOI   = 10'd2;
  localparam logic [ADDR_W-1:0] A_SWSET = 10'd3;
  localparam logic [ADDR_W-1:0] A_SWCLR = 10'd4;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [VEC_W-1:0]  vec_t;
endpackage

// File: rtl/pic_src_cfg.sv
module pic_src_cfg
  import pic_pkg::*;
#(
  parameter int N_PERIPH = 196,
  parameter int N_SW     = 8,
  parameter int WR_W     = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [WR_W-1:0]                  wr_data,
  output logic [(N_PERIPH+N_SW)*PRIO_W-1:0] prio_flat,
  output logic [N_SW-1:0]                  sw_pend
);
  localparam int N_SRC = N_PERIPH + N_SW;

  // per-source priority registers, one address slot each
  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(PRIO_BASE + g);
    logic  slot_we;
    prio_t slot_q;

    assign slot_we = wr_en && (addr == SLOT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_we) slot_q <= wr_data[PRIO_W-1:0];
    end

    assign prio_flat[g*PRIO_W +: PRIO_W] = slot_q;
  end

  // software-raised sources: write-one-to-set / write-one-to-clear
  logic            sw_set_we, sw_clr_we;
  logic [N_SW-1:0] sw_q, sw_d;

  assign sw_set_we = wr_en && (addr == A_SWSET);
  assign sw_clr_we = wr_en && (addr == A_SWCLR);

  always_comb begin
    sw_d = sw_q;
    if (sw_set_we) sw_d = sw_q | wr_data[N_SW-1:0];
    if (sw_clr_we) sw_d = sw_q & ~wr_data[N_SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else        sw_q <= sw_d;
  end

  assign sw_pend = sw_q;

  AST_SWSET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_we |=> ((sw_q & $past(wr_data[N_SW-1:0])) == $past(wr_data[N_SW-1:0]))); // R9
  AST_SWCLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_we |=> ((sw_q & $past(wr_data[N_SW-1:0])) == '0)); // R9
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int N_SRC = 204
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        req_in,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    win_valid,
  output vec_t                    win_vec,
  output prio_t                   win_prio
);
  // stage 1: capture request lines
  logic [N_SRC-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_in;
  end

  // stage 2: priority scan, strict compare keeps the lowest index on ties
  prio_t best_prio;
  vec_t  best_idx;

  always_comb begin
    best_prio = '0;
    best_idx  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_q[i] && (prio_flat[i*PRIO_W +: PRIO_W] > best_prio)) begin
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
        best_idx  = VEC_W'(i);
      end
    end
  end

  logic  valid_d;
  logic  valid_q;
  vec_t  vec_q;
  prio_t prio_q;

  assign valid_d = (best_prio != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      prio_q  <= '0;
    end else begin
      valid_q <= valid_d;
      vec_q   <= best_idx;
      prio_q  <= best_prio;
    end
  end

  assign win_valid = valid_q;
  assign win_vec   = vec_q;
  assign win_prio  = prio_q;

  AST_WIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_prio != '0)); // R5
  AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (int'(win_vec) < N_SRC)); // R3
endmodule

// File: rtl/pic_prio_stack.sv
module pic_prio_stack
  import pic_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  prio_t push_prio,
  input  logic  pop,
  input  logic  set_cur,
  input  prio_t set_val,
  output prio_t cur_prio
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  prio_t            mem [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  prio_t            cur_q, cur_d;
  logic             mem_we;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  prio_t            top_val;

  assign wr_ptr  = PTR_W'(cnt_q);
  assign rd_ptr  = PTR_W'(cnt_q - CNT_W'(1));
  assign top_val = (cnt_q != '0) ? mem[rd_ptr] : '0;

  always_comb begin
    cnt_d  = cnt_q;
    cur_d  = cur_q;
    mem_we = 1'b0;
    if (push) begin
      cur_d = push_prio;
      if (cnt_q < FULL) begin
        mem_we = 1'b1;
        cnt_d  = cnt_q + CNT_W'(1);
      end
    end else if (pop) begin
      cur_d = top_val;
      if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    end else if (set_cur) begin
      cur_d = set_val;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_ptr] <= cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cur_q <= cur_d;
    end
  end

  assign cur_prio = cur_q;

  AST_LIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R7
  AST_PUSH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (cur_q == $past(push_prio))); // R6
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && (cnt_q == '0)) |=> (cur_q == '0)); // R7
  AST_CEIL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cur && !push && !pop) |=> ((cnt_q == $past(cnt_q)) && (cur_q == $past(set_val)))); // R8
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_PERIPH   = 196,
  parameter int N_SW       = 8,
  parameter int LIFO_DEPTH = 16,
  localparam int WR_W      = (N_SW > PRIO_W) ? N_SW : PRIO_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PERIPH-1:0] periph_req,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [WR_W-1:0]     wr_data,
  input  logic                rd_en,
  output logic [RD_W-1:0]     rd_data,
  output logic                irq_o,
  output logic [VEC_W-1:0]    irq_vec_o
);
  localparam int N_SRC = N_PERIPH + N_SW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  // configuration and software sources
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [N_SW-1:0]         sw_pend;

  pic_src_cfg #(.N_PERIPH(N_PERIPH), .N_SW(N_SW), .WR_W(WR_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_ns),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .prio_flat(prio_flat),
    .sw_pend  (sw_pend)
  );

  // arbitration (stages 1 and 2)
  logic  win_valid;
  vec_t  win_vec;
  prio_t win_prio;

  pic_arbiter #(.N_SRC(N_SRC)) u_arb (
    .clk      (clk),
    .rst_n    (rst_ns),
    .req_in   ({sw_pend, periph_req}),
    .prio_flat(prio_flat),
    .win_valid(win_valid),
    .win_vec  (win_vec),
    .win_prio (win_prio)
  );

  // bus decode
  logic  irq_q;
  vec_t  irq_vec_q;
  prio_t irq_prio_q;
  prio_t cur_prio;
  logic  ack_fire, eoi_we, cur_we;

  assign ack_fire = rd_en && (addr == A_ACK) && irq_q;
  assign eoi_we   = wr_en && (addr == A_EOI);
  assign cur_we   = wr_en && (addr == A_CUR);

  pic_prio_stack #(.DEPTH(LIFO_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_ns),
    .push     (ack_fire),
    .push_prio(irq_prio_q),
    .pop      (eoi_we),
    .set_cur  (cur_we),
    .set_val  (wr_data[PRIO_W-1:0]),
    .cur_prio (cur_prio)
  );

  // stage 3: compare against running level, squash on acknowledge
  logic irq_d;

  assign irq_d = !ack_fire && win_valid && (win_prio > cur_prio);

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      irq_q      <= 1'b0;
      irq_vec_q  <= '0;
      irq_prio_q <= '0;
    end else begin
      irq_q      <= irq_d;
      irq_vec_q  <= win_vec;
      irq_prio_q <= win_prio;
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = irq_vec_q;

  // read mux
  always_comb begin
    rd_data = '0;
    if (addr == A_CUR) begin
      rd_data[PRIO_W-1:0] = cur_prio;
    end else if (addr == A_ACK) begin
      rd_data[ACK_VALID_BIT] = irq_q;
      rd_data[VEC_W-1:0]     = irq_vec_q;
    end else if (addr == A_SWSET) begin
      rd_data[N_SW-1:0] = sw_pend;
    end else if ((int'(addr) >= PRIO_BASE) && (int'(addr) < PRIO_BASE + N_SRC)) begin
      rd_data[PRIO_W-1:0] = prio_flat[(int'(addr) - PRIO_BASE)*PRIO_W +: PRIO_W];
    end
  end

  AST_ACK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_ns)
    ack_fire |=> !irq_q); // R6
  AST_IRQ_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_q |-> (irq_prio_q > $past(cur_prio))); // R5
  AST_IDLE_ACK_INERT: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_en && (addr == A_ACK) && !irq_q && !wr_en) |=> (cur_prio == $past(cur_prio))); // R11
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int NP    = 196;
  localparam int NS    = 8;
  localparam int NSRC  = NP + NS;
  localparam int WRW   = 8;
  localparam int A_CUR = 0, A_ACK = 1, A_EOI = 2, A_SWSET = 3, A_SWCLR = 4, A_PBASE = 256;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NP-1:0]   periph_req;
  logic [9:0]      addr;
  logic            wr_en, rd_en;
  logic [WRW-1:0]  wr_data;
  logic [15:0]     rd_data;
  logic            irq_o;
  logic [8:0]      irq_vec_o;

  prio_irq_ctrl #(.N_PERIPH(NP), .N_SW(NS), .LIFO_DEPTH(16)) uut (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .irq_o(irq_o), .irq_vec_o(irq_vec_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  int prio_m [NSRC];
  logic [NS-1:0] sw_m;
  int cur_m;
  int stk [16];
  int sp;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_winner();
    int best = 0;
    int idx = -1;
    for (int i = 0; i < NSRC; i++) begin
      logic pend;
      pend = (i < NP) ? periph_req[i] : sw_m[i-NP];
      if (pend && prio_m[i] > best) begin
        best = prio_m[i];
        idx = i;
      end
    end
    if (best > cur_m) return idx;
    return -1;
  endfunction

  task automatic bus_wr(input int a, input int d);
    addr = 10'(a); wr_data = WRW'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [15:0] d);
    addr = 10'(a); rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_prio(input int s, input int p);
    bus_wr(A_PBASE + s, p);
    prio_m[s] = p;
  endtask

  task automatic do_eoi();
    bus_wr(A_EOI, 0);
    if (sp > 0) begin sp--; cur_m = stk[sp]; end
    else cur_m = 0;
  endtask

  task automatic do_ceiling(input int v);
    bus_wr(A_CUR, v);
    cur_m = v;
  endtask

  task automatic do_swset(input int m);
    bus_wr(A_SWSET, m);
    sw_m = sw_m | NS'(m);
  endtask

  task automatic do_swclr(input int m);
    bus_wr(A_SWCLR, m);
    sw_m = sw_m & ~NS'(m);
  endtask

  task automatic do_ack(input string tag);
    int w;
    logic [15:0] d;
    w = exp_winner();
    bus_rd(A_ACK, d);
    check_eq({tag, " ack valid"}, int'(d[15]), (w >= 0) ? 1 : 0);
    if (w >= 0) begin
      check_eq({tag, " ack vector"}, int'(d[8:0]), w);
      if (sp < 16) begin stk[sp] = cur_m; sp++; end
      cur_m = prio_m[w];
    end
  endtask

  task automatic read_eq(input string tag, input int a, input int exp);
    logic [15:0] d;
    bus_rd(a, d);
    check_eq(tag, int'(d), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < NSRC; i++) prio_m[i] = 0;
    sw_m = '0; cur_m = 0; sp = 0;
    periph_req = '0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check_eq("R1 irq after reset", int'(irq_o), 0);
    read_eq("R1 running priority", A_CUR, 0);
    read_eq("R1 source priority", A_PBASE + 7, 0);
    read_eq("R1 sw pending", A_SWSET, 0);

    // R10 priority register readback
    set_prio(5, 6);
    read_eq("R10 prio readback", A_PBASE + 5, 6);
    set_prio(NSRC - 1, 3);
    read_eq("R10 last slot readback", A_PBASE + NSRC - 1, 3);
    set_prio(NSRC - 1, 0);

    // R2 latency: three edges from request to irq_o
    periph_req[5] = 1'b1;
    @(negedge clk); check_eq("R2 irq after edge 1", int'(irq_o), 0);
    @(negedge clk); check_eq("R2 irq after edge 2", int'(irq_o), 0);
    @(negedge clk); check_eq("R2 irq after edge 3", int'(irq_o), 1);
    check_eq("R3 vector on pin", int'(irq_vec_o), 5);

    // R6 acknowledge
    do_ack("R6");
    check_eq("R6 irq dropped after ack", int'(irq_o), 0);
    read_eq("R6 running priority loaded", A_CUR, 6);

    // R5 strict compare
    idle(5);
    check_eq("R5 equal priority held", int'(irq_o), 0);
    set_prio(9, 6); periph_req[9] = 1'b1; idle(5);
    check_eq("R5 second equal held", int'(irq_o), 0);
    set_prio(9, 7); idle(5);
    check_eq("R5 higher forwarded", int'(irq_o), 1);
    do_ack("R5");
    read_eq("R6 nested level", A_CUR, 7);
    periph_req[3] = 1'b1; idle(5);
    check_eq("R5 priority zero never", int'(irq_o), 0);

    // R7 pops in nesting order
    do_eoi();
    read_eq("R7 first pop", A_CUR, 6);
    do_eoi();
    read_eq("R7 second pop", A_CUR, 0);

    // R4 tie-break: 9 and 12 both at 7
    set_prio(12, 7); periph_req[12] = 1'b1; idle(5);
    do_ack("R4 tie");
    do_eoi();
    do_eoi();
    read_eq("R7 empty pop gives zero", A_CUR, 0);

    // R8 ceiling write does not touch the stack
    idle(5);
    do_ack("R8 setup");
    do_ceiling(12);
    read_eq("R8 ceiling readback", A_CUR, 12);
    idle(5);
    check_eq("R8 ceiling masks", int'(irq_o), 0);
    do_eoi();
    read_eq("R8 single pop after ceiling", A_CUR, 0);

    // R9 / R3 software source behaves like a peripheral
    periph_req = '0;
    set_prio(NP + 3, 9);
    do_swset(8'h08);
    read_eq("R9 sw set readback", A_SWSET, 8);
    idle(5);
    do_ack("R3 sw vector");
    do_eoi();
    do_swclr(8'h08);
    read_eq("R9 sw clear readback", A_SWSET, 0);
    idle(5);
    check_eq("R9 cleared source silent", int'(irq_o), 0);

    // R11 acknowledge with nothing forwarded
    bus_rd(A_ACK, d);
    check_eq("R11 idle ack valid bit", int'(d[15]), 0);
    read_eq("R11 running priority kept", A_CUR, cur_m);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op, s, w;
      op = $urandom_range(0, 6);
      s = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 15) : $urandom_range(NSRC - 16, NSRC - 1);
      case (op)
        0: set_prio(s, $urandom_range(0, 15));
        1: if (s < NP) periph_req[s] = ~periph_req[s];
        2: do_swset(1 << $urandom_range(0, NS - 1));
        3: do_swclr(1 << $urandom_range(0, NS - 1));
        4: do_eoi();
        5: if (cur_m < 15) do_ceiling($urandom_range(cur_m, 15));
        default: do_eoi();
      endcase
      idle(4);
      w = exp_winner();
      check_eq("R4 random irq level", int'(irq_o), (w >= 0) ? 1 : 0);
      do_ack("R4 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule